// File: doc/BRIEF.md
# Thread-Filtered Event Counter Unit

This block is a small performance-monitoring unit. It has two general event counters and one active-cycle counter for each hardware thread. Software reaches all of them through a plain 32-bit register port with byte enables. Each general counter is held in one 32-bit word. The word packs the running count, a per-thread enable mask and a 4-bit source selector. Each counter also has two 4-bit sub-selectors. One picks a line from the core-internal event vector and the other picks a line from the channel event vector.

Event pulses arrive as input vectors. Some are tagged per hardware thread and are filtered by the counter's thread mask. Others are core-global and ignore the mask. When a general counter wraps, it raises a sticky status flag and its own interrupt line. Software arms a sampling period by preloading the negative of the period, masked to 24 bits. A build-time parameter selects a legacy variant. In that variant there is no overflow signalling, and every write to a counter word clears its count.

Top module: `evt_count_unit`

## Requirements
- R1: After reset, every counter word, sub-selector, cycle counter and the status word read as zero, and both interrupt lines are low.
- R2: A counter word (address 0 for counter 0, address 1 for counter 1) holds the count in bits 23:0, the thread mask in bits 27:24 (bit 24+n enables thread n) and the source selector in bits 31:28. A read returns the whole 32-bit word.
- R3: In the default mode, a write updates only the bytes whose byte enable is set. A write with only byte enable 3 changes mask and selector and leaves the count unchanged. Byte enables 2:0 load the matching count bytes.
- R4: A counter whose bits 31:24 are all zero is stopped and holds its count, whatever the event inputs do.
- R5: Selector 0 counts thread-tagged events, and only for threads whose mask bit is set. The count rises by at most one per clock, even when several enabled threads pulse together.
- R6: Selector 1 counts the core-internal event line chosen by the counter's core sub-selector (address 2 for counter 0, 3 for counter 1). Selector 2 counts the channel event line chosen by the channel sub-selector (address 4, 5). Selector 3 counts every clock. All three ignore the thread mask. Selectors 4 to 15 count nothing. Sub-selectors hold 4 bits and read back in bits 3:0.
- R7: In the default mode, a wrap of the count from 0xFFFFFF to 0 sets a sticky flag in the status word (address 6; bit 16 for counter 0, bit 17 for counter 1). Bit i of the interrupt output follows the flag of counter i. Counting continues past the wrap.
- R8: Writing 1 to a status flag clears it, and writing 0 leaves it unchanged. A wrap in the same cycle as the clear leaves the flag set.
- R9: The cycle counter of thread n (address 8+n) rises by one on every clock in which that thread's active input is high. It cannot be stopped, and any write to it clears it to zero.
- R10: With the legacy parameter set, any write to a counter word clears its count to zero, whatever the byte enables. No status flag or interrupt is ever raised.
- R11: A register write takes effect in the clock it is presented. An event in that same clock is not added on top of the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address, used for reads and writes |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| thr_evt | input | NTHR | Thread-tagged event pulses, one bit per thread |
| thr_active | input | NTHR | Per-thread active indication for the cycle counters |
| core_evt | input | N_SUB | Core-internal event pulses (core-global) |
| chan_evt | input | N_SUB | Channel event pulses (core-global) |
| ovf_irq | output | 2 | Overflow interrupt, one line per general counter |

## Verification
The assertions assume that the register port sees at most one write per clock. Two of them hold only across clocks where no write reaches the checked counter: the single-step growth check and the hold-when-stopped check. The overflow check assumes that a wrap can only follow an increment from 0xFFFFFF. The stimulus drives every port on the falling clock edge and holds it for whole cycles. It sends writes and event pulses in separate cycles, except where the write-priority and set-over-clear cases are aimed at on purpose.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 24;
  localparam int ADDR_W  = 4;
  localparam int N_GEN   = 2;
  localparam int OVF_BIT = 16;

  localparam logic [3:0] SRC_THREAD = 4'd0;
  localparam logic [3:0] SRC_CORE   = 4'd1;
  localparam logic [3:0] SRC_CHAN   = 4'd2;
  localparam logic [3:0] SRC_CYCLE  = 4'd3;

  localparam logic [ADDR_W-1:0] A_CORE_SUB = 4'd2;
  localparam logic [ADDR_W-1:0] A_CHAN_SUB = 4'd4;
  localparam logic [ADDR_W-1:0] A_STATUS   = 4'd6;
  localparam int                CYC_BASE   = 8;
endpackage

// File: rtl/evt_select.sv
module evt_select #(
  parameter int NTHR  = 4,
  parameter int N_SUB = 16
) (
  input  logic [3:0]       src_sel,
  input  logic [NTHR-1:0]  thr_mask,
  input  logic [3:0]       core_sub,
  input  logic [3:0]       chan_sub,
  input  logic [NTHR-1:0]  thr_evt,
  input  logic [N_SUB-1:0] core_evt,
  input  logic [N_SUB-1:0] chan_evt,
  output logic             hit
);
  import evt_pkg::*;

  always_comb begin
    case (src_sel)
      SRC_THREAD: hit = |(thr_evt & thr_mask);
      SRC_CORE:   hit = core_evt[core_sub];
      SRC_CHAN:   hit = chan_evt[chan_sub];
      SRC_CYCLE:  hit = 1'b1;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gen_counter.sv
module gen_counter #(
  parameter bit LEGACY = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  input  logic        hit,
  input  logic        ovf_clr,
  output logic [31:0] word,
  output logic        ovf
);
  import evt_pkg::*;

  logic [7:0]       ctrl;
  logic [CNT_W-1:0] cnt;
  logic             run, inc, wrap;

  assign run  = |ctrl;
  assign inc  = run && hit && !wr_en;
  assign wrap = !LEGACY && inc && (cnt == {CNT_W{1'b1}});
  assign word = {ctrl, cnt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      cnt  <= '0;
    end else if (wr_en) begin
      if (wr_be[3]) ctrl <= wr_data[31:24];
      if (LEGACY) cnt <= '0;
      else begin
        for (int b = 0; b < 3; b++)
          if (wr_be[b]) cnt[8*b +: 8] <= wr_data[8*b +: 8];
      end
    end else if (inc) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (wrap)    ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));
  // R4
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && word[31:24] == 8'h00) |=> $stable(cnt));
  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!LEGACY && !wr_en && hit && word[31:24] != 8'h00 && cnt == {CNT_W{1'b1}})
      |=> (ovf && cnt == '0));
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  // R11
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!LEGACY && wr_en && wr_be[2:0] == 3'b111) |=> cnt == $past(wr_data[23:0]));
  // R10
  legacy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LEGACY && wr_en) |=> cnt == '0);
endmodule

// File: rtl/cyc_counter.sv
module cyc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         wr_en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (wr_en)  q <= '0;
    else if (active) q <= q + W'(1);
  end

  // R9
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> q == $past(q) + W'($past(active)));
  // R9
  cyc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == '0);
endmodule

// File: rtl/evt_count_unit.sv
module evt_count_unit #(
  parameter int NTHR   = 4,
  parameter int N_SUB  = 16,
  parameter bit LEGACY = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [3:0]       reg_be,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [NTHR-1:0]  thr_evt,
  input  logic [NTHR-1:0]  thr_active,
  input  logic [N_SUB-1:0] core_evt,
  input  logic [N_SUB-1:0] chan_evt,
  output logic [1:0]       ovf_irq
);
  import evt_pkg::*;

  logic [3:0]  core_sub [N_GEN];
  logic [3:0]  chan_sub [N_GEN];
  logic [31:0] ctr_word [N_GEN];
  logic [31:0] cyc_q    [NTHR];
  logic [N_GEN-1:0] ovf_flag;

  for (genvar i = 0; i < N_GEN; i++) begin : g_gen
    logic hit, wr_i, clr_i;
    assign wr_i  = reg_we && reg_addr == ADDR_W'(i);
    assign clr_i = reg_we && reg_addr == A_STATUS && reg_be[2] && reg_wdata[OVF_BIT+i];

    evt_select #(.NTHR(NTHR), .N_SUB(N_SUB)) u_sel (
      .src_sel (ctr_word[i][31:28]),
      .thr_mask(ctr_word[i][24 +: NTHR]),
      .core_sub(core_sub[i]),
      .chan_sub(chan_sub[i]),
      .thr_evt (thr_evt),
      .core_evt(core_evt),
      .chan_evt(chan_evt),
      .hit     (hit)
    );

    gen_counter #(.LEGACY(LEGACY)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_i),
      .wr_be  (reg_be),
      .wr_data(reg_wdata),
      .hit    (hit),
      .ovf_clr(clr_i),
      .word   (ctr_word[i]),
      .ovf    (ovf_flag[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        core_sub[i] <= '0;
        chan_sub[i] <= '0;
      end else if (reg_we && reg_be[0]) begin
        if (reg_addr == A_CORE_SUB + ADDR_W'(i)) core_sub[i] <= reg_wdata[3:0];
        if (reg_addr == A_CHAN_SUB + ADDR_W'(i)) chan_sub[i] <= reg_wdata[3:0];
      end
    end
  end

  for (genvar n = 0; n < NTHR; n++) begin : g_cyc
    cyc_counter #(.W(WORD_W)) u_cyc (
      .clk   (clk),
      .rst_n (rst_n),
      .active(thr_active[n]),
      .wr_en (reg_we && reg_addr == ADDR_W'(CYC_BASE + n)),
      .q     (cyc_q[n])
    );
  end

  assign ovf_irq = ovf_flag;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N_GEN; i++) begin
      if (reg_addr == ADDR_W'(i))               reg_rdata = ctr_word[i];
      if (reg_addr == A_CORE_SUB + ADDR_W'(i))  reg_rdata = {28'd0, core_sub[i]};
      if (reg_addr == A_CHAN_SUB + ADDR_W'(i))  reg_rdata = {28'd0, chan_sub[i]};
    end
    if (reg_addr == A_STATUS) reg_rdata[OVF_BIT +: N_GEN] = ovf_flag;
    for (int n = 0; n < NTHR; n++)
      if (reg_addr == ADDR_W'(CYC_BASE + n)) reg_rdata = cyc_q[n];
  end

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_irq[0]) |-> $past(ctr_word[0][23:0]) == 24'hFFFFFF);
  // R10
  legacy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    LEGACY |-> ovf_irq == 2'b00);
endmodule

// File: tb/evt_count_unit_bench.sv
module evt_count_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, lg_we = 1'b0;
  logic [3:0]  reg_addr = '0, reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, lg_rdata;
  logic [3:0]  thr_evt = '0, thr_active = '0;
  logic [15:0] core_evt = '0, chan_evt = '0;
  logic [1:0]  irq, lg_irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  initial forever #4 clk = ~clk;

  evt_count_unit u_evt_count_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .thr_evt(thr_evt), .thr_active(thr_active),
    .core_evt(core_evt), .chan_evt(chan_evt), .ovf_irq(irq));

  evt_count_unit #(.LEGACY(1'b1)) u_evt_count_unit_legacy (
    .clk(clk), .rst_n(rst_n), .reg_we(lg_we), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(lg_rdata), .thr_evt(thr_evt), .thr_active(thr_active),
    .core_evt(core_evt), .chan_evt(chan_evt), .ovf_irq(lg_irq));

  // monitor: pops expected items and compares against what the design shows
  initial forever begin
    item_t it;
    logic [31:0] got;
    @(negedge clk); #1;
    while (q.size() > 0) begin
      it = q.pop_front();
      case (it.kind)
        0: got = rdata;
        1: got = {30'd0, irq};
        2: got = lg_rdata;
        default: got = {30'd0, lg_irq};
      endcase
      checks++;
      if (got !== it.exp) begin
        failures++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic chk(int kind, logic [3:0] a, logic [31:0] e, string tag);
    reg_addr = a;
    q.push_back('{kind, e, tag});
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic [3:0] be);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic lg_wr(logic [3:0] a, logic [31:0] d, logic [3:0] be);
    lg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    lg_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    chk(0, 4'd0, 32'h0, "R1 ctr0");
    chk(0, 4'd1, 32'h0, "R1 ctr1");
    chk(0, 4'd2, 32'h0, "R1 core sub");
    chk(0, 4'd6, 32'h0, "R1 status");
    chk(0, 4'd9, 32'h0, "R1 cycle thread1");
    chk(1, 4'd0, 32'h0, "R1 irq");
    chk(2, 4'd0, 32'h0, "R1 legacy ctr0");

    // R2 layout and readback
    wr(4'd0, 32'h0500_0010, 4'hF);
    chk(0, 4'd0, 32'h0500_0010, "R2 word readback");
    // R5 thread filter: mask = threads 0 and 2
    thr_evt = 4'b0010; idle(3); thr_evt = '0;
    chk(0, 4'd0, 32'h0500_0010, "R5 masked thread ignored");
    thr_evt = 4'b0100; idle(3); thr_evt = '0;
    chk(0, 4'd0, 32'h0500_0013, "R5 enabled thread counted");
    thr_evt = 4'b0101; idle(1); thr_evt = '0;
    chk(0, 4'd0, 32'h0500_0014, "R5 at most one per clock");

    // R3 top-byte-only write, R4 stopped counter
    wr(4'd0, 32'h00AB_CDEF, 4'b1000);
    chk(0, 4'd0, 32'h0000_0014, "R3 top byte write keeps count");
    thr_evt = 4'b1111; core_evt = '1; chan_evt = '1; idle(3);
    thr_evt = '0; core_evt = '0; chan_evt = '0;
    chk(0, 4'd0, 32'h0000_0014, "R4 stopped counter holds");

    // R6 core-internal source via sub-selector, mask ignored
    wr(4'd2, 32'h5, 4'hF);
    chk(0, 4'd2, 32'h5, "R6 core sub readback");
    wr(4'd0, 32'h1000_0000, 4'hF);
    core_evt = 16'h0020; idle(2); core_evt = 16'h0010; idle(1); core_evt = '0;
    chk(0, 4'd0, 32'h1000_0002, "R6 core event counted");
    // R6 channel source on counter 1
    wr(4'd5, 32'h3, 4'hF);
    wr(4'd1, 32'h2000_0000, 4'hF);
    chan_evt = 16'h0008; idle(4); chan_evt = 16'h0004; idle(2); chan_evt = '0;
    chk(0, 4'd1, 32'h2000_0004, "R6 channel event counted");
    wr(4'd1, 32'h3000_0000, 4'hF);
    idle(6);
    chk(0, 4'd1, 32'h3000_0006, "R6 cycle source");
    wr(4'd1, 32'h7000_0064, 4'hF);
    thr_evt = '1; core_evt = '1; chan_evt = '1; idle(3);
    thr_evt = '0; core_evt = '0; chan_evt = '0;
    chk(0, 4'd1, 32'h7000_0064, "R6 unused selector counts nothing");

    // R3 / R11 count-byte load on a running counter
    wr(4'd1, 32'h3000_0000, 4'b1000);
    wr(4'd1, 32'h0000_0050, 4'b0111);
    chk(0, 4'd1, 32'h3000_0050, "R11 write wins over event, R3 low bytes");
    wr(4'd1, 32'h0, 4'b1000);
    chk(0, 4'd1, 32'h0000_0051, "R4 stop keeps count");
    idle(3);
    chk(0, 4'd1, 32'h0000_0051, "R4 still held");

    // R7 wrap and sticky flag
    wr(4'd0, 32'h30FF_FFFD, 4'hF);
    idle(2);
    chk(0, 4'd0, 32'h30FF_FFFF, "R7 before wrap");
    chk(0, 4'd6, 32'h0001_0000, "R7 status flag set");
    chk(1, 4'd0, 32'h1, "R7 irq line");
    wr(4'd0, 32'h0, 4'b1000);
    chk(0, 4'd0, 32'h0000_0002, "R7 counting continues");

    // R8 write-one-to-clear
    wr(4'd6, 32'h0, 4'hF);
    chk(0, 4'd6, 32'h0001_0000, "R8 zero write keeps flag");
    wr(4'd6, 32'h0001_0000, 4'hF);
    chk(0, 4'd6, 32'h0, "R8 flag cleared");
    chk(1, 4'd0, 32'h0, "R8 irq dropped");
    wr(4'd0, 32'h30FF_FFFF, 4'hF);
    wr(4'd6, 32'h0001_0000, 4'hF);
    chk(0, 4'd6, 32'h0001_0000, "R8 set wins over clear");
    wr(4'd0, 32'h0, 4'b1000);
    wr(4'd6, 32'h0001_0000, 4'hF);

    // R9 cycle counters
    thr_active = 4'b0010; idle(5); thr_active = '0;
    chk(0, 4'd9, 32'd5, "R9 active cycles");
    chk(0, 4'd8, 32'd0, "R9 inactive thread");
    thr_active = 4'b0010; idle(3);
    wr(4'd9, 32'hFFFF_FFFF, 4'hF);
    thr_active = '0;
    chk(0, 4'd9, 32'd0, "R9 write clears");

    // R10 legacy variant
    lg_wr(4'd0, 32'h3000_0123, 4'hF);
    chk(2, 4'd0, 32'h3000_0000, "R10 write clears count");
    idle(3);
    chk(2, 4'd0, 32'h3000_0004, "R10 legacy counts");
    lg_wr(4'd0, 32'h3000_0000, 4'b1000);
    chk(2, 4'd0, 32'h3000_0000, "R10 top-byte write clears");
    chk(2, 4'd6, 32'h0, "R10 no status");
    chk(3, 4'd0, 32'h0, "R10 no irq");
    lg_wr(4'd0, 32'h0, 4'hF);

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule